// File: doc/BRIEF.md
# DMA Transfer Counter Engine

This block tracks a single DMA data transfer between a storage target and system memory inside a bus controller. Software loads a 16-bit transfer count one byte at a time. A command carrying the DMA flag copies that count into a readable snapshot. The start command then opens a burst. The burst length is the count clamped against the magnitude of a signed device residual. A command-capture mode clamps it to a fixed small limit instead.

The target announces buffered data through an available-length input. For each chunk the engine raises one memory request, with a direction bit and a length, and holds it until the memory side acknowledges it. After every chunk it updates the residual. When a chunk drains the target buffer, the engine decides whether to complete at once or to wait. Completion raises a terminal-count event for the interrupt logic. A deferred completion fires later, when the target delivers more data.

Top module: `xfer_count_engine`

## Requirements
- R1: The transfer length is `cnt_mid * 256 + cnt_lo`. A length of 0 means 65536 bytes.
- R2: A command byte with bit 7 set copies the two host-written count bytes into `cnt_rd`. A command byte without bit 7 leaves `cnt_rd` unchanged.
- R3: Writing either count byte clears `tc_flag` on the next cycle.
- R4: Command byte 0x90 starts a burst when the engine is idle. The burst length is the minimum of the transfer length and the magnitude of the residual. With `capture_mode` high it is the minimum of the transfer length and CAP_LIMIT (32).
- R5: A negative residual means the transfer goes toward the device (`mem_to_dev`=1). In that case each finished chunk adds its length to the residual. Otherwise each finished chunk subtracts its length from the residual.
- R6: With no target data available, the engine raises no request and does not complete. Each chunk length is the minimum of the bytes left in the burst and the available length.
- R7: On completion, the cycle after the triggering event shows the following:
  - `tc_flag`=1 and `irq`=1;
  - `intr_code`=0x10 and `cnt_rd`=0;
  - a one-cycle `side_clr` pulse.
- R8: When a chunk empties the target buffer, `tgt_next` pulses. Completion is then deferred if the transfer goes toward the device, if burst bytes remain, or if the residual is zero. Otherwise the engine completes at once. A chunk that leaves target data unused completes at once.
- R9: Suppose target data arrives while the engine is idle with no burst bytes left. If the loaded length is nonzero and the residual is zero or negative, the deferred completion fires. Loading a residual clears the loaded length, and then arriving data does not complete.
- R10: A memory request keeps `mem_req`, `mem_len` and `mem_to_dev` stable until `mem_done` is seen.
- R11: In capture mode the engine issues one request toward the device and then pulses `cap_done`. It sets the residual to 0 and raises no completion.
- R12: `irq_ack` clears `irq` and `intr_code` and leaves `tc_flag` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr_lo | input | 1 | Write strobe, low count byte |
| cnt_wr_mid | input | 1 | Write strobe, middle count byte |
| cnt_wdata | input | 8 | Count byte data |
| cmd_valid | input | 1 | Command strobe |
| cmd_byte | input | 8 | Command byte; bit 7 = DMA flag |
| capture_mode | input | 1 | Command-capture mode select |
| resid_load | input | 1 | Load a new device residual (idle only) |
| resid_in | input | CNT_W+2 | Signed residual value |
| tgt_valid | input | 1 | Target presents new buffered data |
| tgt_len | input | CNT_W+1 | Length of the target data |
| tgt_next | output | 1 | Target buffer drained, pulse |
| mem_req | output | 1 | Memory request |
| mem_to_dev | output | 1 | 1 = read memory toward device |
| mem_len | output | CNT_W+1 | Request length in bytes |
| mem_done | input | 1 | Memory acknowledge |
| cnt_rd | output | CNT_W | Readable count snapshot |
| tc_flag | output | 1 | Terminal-count status |
| intr_code | output | 8 | Interrupt cause code |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| side_clr | output | 1 | Pulse to clear sequence-step and flags |
| cap_done | output | 1 | Capture request finished, pulse |
| resid_out | output | CNT_W+2 | Current signed residual |
| busy | output | 1 | Burst in progress |

## Verification
The bench checks the residual after every stage and the length and direction of each request. A wrong sign convention or a missing clamp therefore shows up as a mismatch in the scoreboard.

It covers a zero count with a residual larger than 65536. A design that read zero as zero would never request and would leave the scoreboard queue full.

It covers each of the three deferral causes, and it checks that the following arrival of target data completes. A design that completed early raises `irq` too soon. A design that never completed stays silent.

It also covers a partially used target buffer, a non-DMA command, and capture mode. A design that forgot the immediate completion, loaded the snapshot without the DMA flag, or treated capture as a normal transfer is caught.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RUN  = 2'd1,
        XS_REQ  = 2'd2
    } xfer_st_e;

    // low seven bits of the transfer-start command
    localparam logic [6:0] OP_XFER = 7'h10;
    // interrupt cause written on completion
    localparam logic [7:0] CAUSE_SVC = 8'h10;
endpackage

// File: rtl/xfer_len_calc.sv
module xfer_len_calc #(
    parameter int CNT_W     = 16,
    parameter int CAP_LIMIT = 32
) (
    input  logic [CNT_W-1:0]        cnt,
    input  logic signed [CNT_W+1:0] resid,
    input  logic                    cap,
    output logic [CNT_W:0]          dmalen,
    output logic [CNT_W:0]          burst,
    output logic                    to_dev
);
    localparam int LEN_W = CNT_W + 1;
    localparam int RES_W = CNT_W + 2;

    logic [RES_W-1:0] mag;
    logic [RES_W-1:0] lim;

    always_comb begin
        dmalen = (cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt};
        to_dev = resid[RES_W-1];
        mag    = to_dev ? $unsigned(-resid) : $unsigned(resid);
        lim    = cap ? RES_W'(CAP_LIMIT) : mag;
        burst  = ({1'b0, dmalen} < lim) ? dmalen : lim[LEN_W-1:0];
    end
endmodule

// File: rtl/xfer_cnt_regs.sv
module xfer_cnt_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr_lo,
    input  logic             cnt_wr_mid,
    input  logic [7:0]       cnt_wdata,
    input  logic             cmd_dma,
    input  logic             start,
    input  logic             irq_ack,
    input  logic             done_evt,
    output logic [CNT_W-1:0] host_cnt,
    output logic [CNT_W-1:0] cnt_rd,
    output logic             tc_flag,
    output logic [7:0]       intr_code,
    output logic             irq,
    output logic             side_clr
);
    import xfer_cnt_pkg::*;

    localparam int HI_W = CNT_W - 8;

    typedef struct packed {
        logic [7:0]      host_lo;
        logic [HI_W-1:0] host_mid;
        logic [CNT_W-1:0] rd_cnt;
        logic            tc;
        logic [7:0]      intr;
        logic            irq;
        logic            clr;
    } regs_s;

    regs_s q, d;

    always_comb begin
        d     = q;
        d.clr = 1'b0;
        if (cnt_wr_lo) begin
            d.host_lo = cnt_wdata;
            d.tc      = 1'b0;
        end
        if (cnt_wr_mid) begin
            d.host_mid = cnt_wdata[HI_W-1:0];
            d.tc       = 1'b0;
        end
        if (cmd_dma)
            d.rd_cnt = {q.host_mid, q.host_lo};
        if (start)
            d.tc = 1'b0;
        if (irq_ack) begin
            d.irq  = 1'b0;
            d.intr = '0;
        end
        if (done_evt) begin
            d.tc     = 1'b1;
            d.intr   = CAUSE_SVC;
            d.rd_cnt = '0;
            d.irq    = 1'b1;
            d.clr    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign host_cnt  = {q.host_mid, q.host_lo};
    assign cnt_rd    = q.rd_cnt;
    assign tc_flag   = q.tc;
    assign intr_code = q.intr;
    assign irq       = q.irq;
    assign side_clr  = q.clr;

    // R2: snapshot follows the host bytes after a DMA-flagged command
    a_r2_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_dma && !done_evt) |=> (cnt_rd == $past(host_cnt)));

    // R3: a count write drops terminal count
    a_r3_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_wr_lo || cnt_wr_mid) && !done_evt) |=> !tc_flag);

    // R7: completion state
    a_r7_complete: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (irq && tc_flag && intr_code == CAUSE_SVC && cnt_rd == '0 && side_clr));

    // R12: acknowledge clears the request, keeps terminal count
    a_r12_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !done_evt && !start && !cnt_wr_lo && !cnt_wr_mid)
        |=> (!irq && intr_code == 8'h00 && tc_flag == $past(tc_flag)));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq #(
    parameter int CNT_W     = 16,
    parameter int CAP_LIMIT = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CNT_W:0]          dmalen,
    input  logic [CNT_W:0]          burst,
    input  logic                    burst_to_dev,
    input  logic                    cap_in,
    input  logic                    resid_load,
    input  logic signed [CNT_W+1:0] resid_in,
    input  logic                    tgt_valid,
    input  logic [CNT_W:0]          tgt_len,
    input  logic                    mem_done,
    output logic                    mem_req,
    output logic [CNT_W:0]          mem_len,
    output logic                    mem_to_dev,
    output logic                    done_evt,
    output logic                    tgt_next,
    output logic                    cap_done,
    output logic signed [CNT_W+1:0] resid,
    output logic                    busy
);
    import xfer_cnt_pkg::*;

    localparam int LEN_W = CNT_W + 1;
    localparam int RES_W = CNT_W + 2;

    typedef struct packed {
        xfer_st_e          st;
        logic [LEN_W-1:0]  left;
        logic [LEN_W-1:0]  avail;
        logic [LEN_W-1:0]  loaded;
        logic [LEN_W-1:0]  chunk;
        logic signed [RES_W-1:0] resid;
        logic              to_dev;
        logic              cap;
        logic              nxt;
        logic              capd;
    } seq_s;

    seq_s q, d;

    logic [LEN_W-1:0]        chunk_min;
    logic [LEN_W-1:0]        left_nx;
    logic [LEN_W-1:0]        avail_nx;
    logic signed [RES_W-1:0] resid_nx;
    logic signed [RES_W-1:0] chunk_s;

    always_comb begin
        d        = q;
        d.nxt    = 1'b0;
        d.capd   = 1'b0;
        done_evt = 1'b0;
        chunk_min = (q.left < q.avail) ? q.left : q.avail;
        chunk_s   = $signed({1'b0, q.chunk});
        left_nx   = q.left - q.chunk;
        avail_nx  = q.avail - q.chunk;
        resid_nx  = q.to_dev ? (q.resid + chunk_s) : (q.resid - chunk_s);
        case (q.st)
            XS_IDLE: begin
                if (resid_load) begin
                    d.resid  = resid_in;
                    d.left   = '0;
                    d.loaded = '0;
                    d.avail  = '0;
                end else if (start) begin
                    d.loaded = dmalen;
                    d.left   = burst;
                    d.to_dev = cap_in ? 1'b1 : burst_to_dev;
                    d.cap    = cap_in;
                    if (burst != '0)
                        d.st = XS_RUN;
                end else if (tgt_valid) begin
                    d.avail = tgt_len;
                    if (q.loaded != '0 && (q.resid[RES_W-1] || q.resid == '0))
                        done_evt = 1'b1;
                end
            end
            XS_RUN: begin
                if (q.cap) begin
                    d.chunk = q.left;
                    d.st    = XS_REQ;
                end else if (q.avail != '0) begin
                    d.chunk = chunk_min;
                    d.st    = XS_REQ;
                end else if (tgt_valid) begin
                    d.avail = tgt_len;
                end
            end
            XS_REQ: begin
                if (mem_done) begin
                    if (q.cap) begin
                        d.capd   = 1'b1;
                        d.left   = '0;
                        d.resid  = '0;
                        d.loaded = '0;
                        d.cap    = 1'b0;
                        d.st     = XS_IDLE;
                    end else begin
                        d.left  = left_nx;
                        d.avail = avail_nx;
                        d.resid = resid_nx;
                        if (avail_nx == '0) begin
                            d.nxt = 1'b1;
                            if (q.to_dev || left_nx != '0 || resid_nx == '0) begin
                                d.st = (left_nx != '0) ? XS_RUN : XS_IDLE;
                            end else begin
                                done_evt = 1'b1;
                                d.st     = XS_IDLE;
                            end
                        end else begin
                            done_evt = 1'b1;
                            d.st     = XS_IDLE;
                        end
                    end
                end
            end
            default: d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= XS_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_req    = (q.st == XS_REQ);
    assign mem_len    = q.chunk;
    assign mem_to_dev = q.to_dev;
    assign tgt_next   = q.nxt;
    assign cap_done   = q.capd;
    assign resid      = q.resid;
    assign busy       = (q.st != XS_IDLE);

    // R10: request fields stay put until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_len) && $stable(mem_to_dev)));

    // R6: a chunk is never empty and never exceeds the bytes left
    a_r6_chunk_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0 && mem_len <= q.left));

    // R4: capture bursts respect the capture limit
    a_r4_cap_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && q.cap) |-> (mem_len <= LEN_W'(CAP_LIMIT)));

    // R11: capture finish leaves a zero residual
    a_r11_cap_resid: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |-> (resid == '0 && !busy));
endmodule

// File: rtl/xfer_count_engine.sv
module xfer_count_engine #(
    parameter int CNT_W     = 16,
    parameter int CAP_LIMIT = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cnt_wr_lo,
    input  logic                    cnt_wr_mid,
    input  logic [7:0]              cnt_wdata,
    input  logic                    cmd_valid,
    input  logic [7:0]              cmd_byte,
    input  logic                    capture_mode,
    input  logic                    resid_load,
    input  logic signed [CNT_W+1:0] resid_in,
    input  logic                    tgt_valid,
    input  logic [CNT_W:0]          tgt_len,
    output logic                    tgt_next,
    output logic                    mem_req,
    output logic                    mem_to_dev,
    output logic [CNT_W:0]          mem_len,
    input  logic                    mem_done,
    output logic [CNT_W-1:0]        cnt_rd,
    output logic                    tc_flag,
    output logic [7:0]              intr_code,
    output logic                    irq,
    input  logic                    irq_ack,
    output logic                    side_clr,
    output logic                    cap_done,
    output logic signed [CNT_W+1:0] resid_out,
    output logic                    busy
);
    import xfer_cnt_pkg::*;

    localparam int LEN_W = CNT_W + 1;
    localparam int RES_W = CNT_W + 2;

    logic                    cmd_dma;
    logic                    start;
    logic                    done_evt;
    logic [CNT_W-1:0]        host_cnt;
    logic [LEN_W-1:0]        dmalen;
    logic [LEN_W-1:0]        burst;
    logic                    burst_to_dev;
    logic signed [RES_W-1:0] resid;

    assign cmd_dma = cmd_valid && cmd_byte[7];
    assign start   = cmd_dma && (cmd_byte[6:0] == OP_XFER);

    xfer_cnt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr_lo (cnt_wr_lo),
        .cnt_wr_mid(cnt_wr_mid),
        .cnt_wdata (cnt_wdata),
        .cmd_dma   (cmd_dma),
        .start     (start),
        .irq_ack   (irq_ack),
        .done_evt  (done_evt),
        .host_cnt  (host_cnt),
        .cnt_rd    (cnt_rd),
        .tc_flag   (tc_flag),
        .intr_code (intr_code),
        .irq       (irq),
        .side_clr  (side_clr)
    );

    xfer_len_calc #(.CNT_W(CNT_W), .CAP_LIMIT(CAP_LIMIT)) u_calc (
        .cnt   (host_cnt),
        .resid (resid),
        .cap   (capture_mode),
        .dmalen(dmalen),
        .burst (burst),
        .to_dev(burst_to_dev)
    );

    xfer_seq #(.CNT_W(CNT_W), .CAP_LIMIT(CAP_LIMIT)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dmalen      (dmalen),
        .burst       (burst),
        .burst_to_dev(burst_to_dev),
        .cap_in      (capture_mode),
        .resid_load  (resid_load),
        .resid_in    (resid_in),
        .tgt_valid   (tgt_valid),
        .tgt_len     (tgt_len),
        .mem_done    (mem_done),
        .mem_req     (mem_req),
        .mem_len     (mem_len),
        .mem_to_dev  (mem_to_dev),
        .done_evt    (done_evt),
        .tgt_next    (tgt_next),
        .cap_done    (cap_done),
        .resid       (resid),
        .busy        (busy)
    );

    assign resid_out = resid;
endmodule

// File: tb/sim_xfer_count_engine.sv
`timescale 1ns/1ps
module sim_xfer_count_engine;
    localparam int CNT_W = 16;
    localparam int LEN_W = CNT_W + 1;
    localparam int RES_W = CNT_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_wr_lo = 0, cnt_wr_mid = 0, cmd_valid = 0, capture_mode = 0;
    logic [7:0] cnt_wdata = '0, cmd_byte = '0;
    logic resid_load = 0, tgt_valid = 0, mem_done = 0, irq_ack = 0;
    logic signed [RES_W-1:0] resid_in = '0;
    logic [LEN_W-1:0] tgt_len = '0;
    logic tgt_next, mem_req, mem_to_dev, tc_flag, irq, side_clr, cap_done, busy;
    logic [LEN_W-1:0] mem_len;
    logic [CNT_W-1:0] cnt_rd;
    logic [7:0] intr_code;
    logic signed [RES_W-1:0] resid_out;

    always #2 clk = ~clk;

    xfer_count_engine u0 (
        .clk(clk), .rst_n(rst_n), .cnt_wr_lo(cnt_wr_lo), .cnt_wr_mid(cnt_wr_mid),
        .cnt_wdata(cnt_wdata), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .capture_mode(capture_mode), .resid_load(resid_load), .resid_in(resid_in),
        .tgt_valid(tgt_valid), .tgt_len(tgt_len), .tgt_next(tgt_next),
        .mem_req(mem_req), .mem_to_dev(mem_to_dev), .mem_len(mem_len),
        .mem_done(mem_done), .cnt_rd(cnt_rd), .tc_flag(tc_flag),
        .intr_code(intr_code), .irq(irq), .irq_ack(irq_ack), .side_clr(side_clr),
        .cap_done(cap_done), .resid_out(resid_out), .busy(busy)
    );

    int checks = 0;
    int fails = 0;
    int n_next = 0;
    int n_cap = 0;
    int n_clr = 0;
    bit finished = 0;
    longint exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what, input longint act, input longint exp);
        chk(act == exp, req, what, act, exp);
    endtask

    // expected request: length in low bits, direction above
    task automatic push_req(input longint len, input bit dir);
        exp_q.push_back({dir, len[31:0]});
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_lo(input logic [7:0] b);
        @(negedge clk); cnt_wr_lo = 1; cnt_wdata = b;
        @(negedge clk); cnt_wr_lo = 0;
    endtask

    task automatic wr_mid(input logic [7:0] b);
        @(negedge clk); cnt_wr_mid = 1; cnt_wdata = b;
        @(negedge clk); cnt_wr_mid = 0;
    endtask

    task automatic cmd(input logic [7:0] b);
        @(negedge clk); cmd_valid = 1; cmd_byte = b;
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic set_resid(input longint v);
        @(negedge clk); resid_load = 1; resid_in = RES_W'(v);
        @(negedge clk); resid_load = 0;
    endtask

    task automatic tgt(input longint len);
        @(negedge clk); tgt_valid = 1; tgt_len = LEN_W'(len);
        @(negedge clk); tgt_valid = 0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    // monitor: pops expected requests and answers them
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected request len", longint'(mem_len), 0);
                end else begin
                    longint e;
                    e = exp_q.pop_front();
                    eq("R4", "request length", longint'(mem_len), longint'(e[31:0]));
                    eq("R5", "request direction", longint'(mem_to_dev), longint'(e[32]));
                end
                repeat (2) @(negedge clk);
                mem_done = 1;
                @(negedge clk);
                mem_done = 0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (tgt_next) n_next++;
            if (cap_done) n_cap++;
            if (side_clr) n_clr++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(0, "WATCHDOG", "run timed out", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        eq("R7", "reset irq", irq, 0);
        eq("R3", "reset tc", tc_flag, 0);
        eq("R2", "reset cnt_rd", cnt_rd, 0);
        eq("R10", "reset mem_req", mem_req, 0);

        // from device, two chunks, partial target buffer completes
        set_resid(20); wr_lo(8); wr_mid(0);
        push_req(5, 0); push_req(3, 0);
        cmd(8'h90);
        eq("R2", "snapshot after DMA command", cnt_rd, 8);
        settle(6);
        eq("R6", "no request without data", mem_req, 0);
        eq("R6", "no completion without data", irq, 0);
        tgt(5); settle(15);
        eq("R8", "bytes remain defers", irq, 0);
        eq("R5", "residual after first chunk", resid_out, 15);
        eq("R8", "drain pulse count", n_next, 1);
        tgt(10); settle(15);
        eq("R7", "irq on completion", irq, 1);
        eq("R7", "intr code", intr_code, 16);
        eq("R7", "tc set", tc_flag, 1);
        eq("R7", "cnt_rd zeroed", cnt_rd, 0);
        eq("R7", "side clear pulse", n_clr, 1);
        eq("R5", "residual after second chunk", resid_out, 12);
        eq("R8", "no drain on partial use", n_next, 1);

        ack();
        eq("R12", "irq cleared", irq, 0);
        eq("R12", "intr cleared", intr_code, 0);
        eq("R12", "tc kept", tc_flag, 1);
        wr_lo(4);
        eq("R3", "tc cleared by count write", tc_flag, 0);
        wr_mid(0);

        cmd(8'h10);
        eq("R2", "no snapshot without DMA flag", cnt_rd, 0);
        eq("R4", "no start without DMA flag", busy, 0);

        // leftover target data: 7 bytes, burst 4
        push_req(4, 0);
        cmd(8'h90); settle(15);
        eq("R8", "unused data completes", irq, 1);
        eq("R5", "residual after partial", resid_out, 8);
        ack();

        // residual reaches zero: deferred
        set_resid(6); wr_lo(6);
        push_req(6, 0);
        cmd(8'h90);
        tgt(6); settle(15);
        eq("R8", "zero residual defers", irq, 0);
        eq("R5", "residual zero", resid_out, 0);
        eq("R8", "drain pulse count 2", n_next, 2);
        tgt(4); settle(2);
        eq("R9", "deferred completion fires", irq, 1);
        ack();
        set_resid(0);
        tgt(4); settle(2);
        eq("R9", "no completion without loaded count", irq, 0);

        // zero count means 65536, toward device
        set_resid(-70000); wr_lo(0); wr_mid(0);
        push_req(65536, 1);
        cmd(8'h90);
        tgt(65536); settle(15);
        eq("R8", "toward device defers", irq, 0);
        eq("R5", "residual toward device", resid_out, -4464);
        tgt(3); settle(2);
        eq("R9", "deferred completion toward device", irq, 1);
        ack();

        // byte order of the count
        set_resid(300); wr_lo(8'h02); wr_mid(8'h01);
        push_req(258, 0);
        cmd(8'h90);
        eq("R1", "count byte order", cnt_rd, 258);
        tgt(300); settle(15);
        eq("R1", "completion after 258", irq, 1);
        eq("R5", "residual after 258", resid_out, 42);
        ack();

        // capture mode
        capture_mode = 1;
        wr_lo(100); wr_mid(0);
        push_req(32, 1);
        cmd(8'h90); settle(15);
        capture_mode = 0;
        eq("R11", "capture done pulse", n_cap, 1);
        eq("R11", "no completion in capture", irq, 0);
        eq("R11", "capture residual", resid_out, 0);

        settle(4);
        eq("R6", "all expected requests seen", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule